// File: doc/BRIEF.md
# Bridge Offset Calibration Sequencer

This block controls a magnetoresistive bridge sensor that has set and reset straps. To calibrate, it drives a SET strap pulse and converts the bridge output through an external ADC. It then drives a RESET strap pulse and converts again. The midpoint of the two readings is the combined offset of the bridge and its front end. That offset is held in a register and subtracted from every later conversion.

The bridge keeps its magnetisation after the RESET pulse. Ordinary measurement requests therefore only run a single conversion and never pulse the straps. A countdown timer repeats the calibration after a programmable number of cycles, so that drift with temperature is tracked. Every spacing in the strap sequence is a clock-count parameter:

- the lead-in before SET;
- the pulse width;
- the gap before a conversion;
- the SET-to-RESET separation;
- the settle time after RESET.

Top module: `bridge_cal_seq`

## Requirements
- R1: A calibration drives the outputs in a fixed order. It pulses `set_pulse`, converts, pulses `rst_pulse`, then converts again. Each pulse is high for exactly `PULSE_CYC` cycles, and the two pulses are never high together.
- R2: At least `WAIT_A_CYC` cycles pass between the start of a calibration and the rise of `set_pulse`. At least `GAP_B_CYC` low cycles separate the fall of `set_pulse` from the next `adc_start`. No `adc_start` is issued while a strap pulse is high.
- R3: The rise of `rst_pulse` comes at least `SEP_C_CYC` cycles after the rise of `set_pulse`. At least `SETTLE_D_CYC` cycles separate the fall of `rst_pulse` from the conversion that follows.
- R4: `adc_data` and `corr_data` are two's complement values. From the reading after SET (vs) and the reading after RESET (vr), the offset is floor((vs+vr)/2), formed in one extra bit. A calibration that completes presents vr minus that offset on `corr_data`, with `corr_valid` high for one cycle.
- R5: A one-cycle `meas_req` pulse, once at least one calibration has completed, runs one conversion without strap pulses. It then presents the sample minus the stored offset on `corr_data`, with `corr_valid` high for one cycle.
- R6: A `meas_req` that arrives during a calibration is held. It is served once that calibration's own result has been presented.
- R7: Until a calibration has completed, `meas_req` has no effect and `corr_valid` stays low.
- R8: `adc_start` is high for a single cycle. If `adc_done` does not arrive within `ADC_TO_CYC` cycles, `cal_err` rises and then stays high until reset. A calibration that times out this way is abandoned, with no further strap pulse.
- R9: A calibration begins right after reset. A new one begins `RECAL_CYC` + `WAIT_A_CYC` + 1 cycles after the previous calibration completes or is abandoned.
- R10: While reset is held, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_req | input | 1 | One-cycle request for a corrected reading |
| set_pulse | output | 1 | SET strap drive |
| rst_pulse | output | 1 | RESET strap drive |
| adc_start | output | 1 | One-cycle conversion start |
| adc_done | input | 1 | Conversion finished; `adc_data` valid this cycle |
| adc_data | input | DATA_W | Two's complement conversion result |
| corr_data | output | DATA_W+1 | Two's complement offset-corrected value |
| corr_valid | output | 1 | `corr_data` valid for one cycle |
| cal_err | output | 1 | Sticky conversion-timeout flag |

## Verification
Calibrations are run with fixed corner pairs and then with random pairs:

- both readings at full-scale positive;
- both at full-scale negative;
- readings of -1 and 0;
- readings at opposite extremes.

The equal pairs show whether the extra sum bit is present, since without it the result wraps. The -1/0 pair separates a floor of the halved sum from truncation toward zero. Corrected readings taken at the range ends check the widened subtraction. A silent ADC right after reset exercises the timeout and the abandoned sequence, and also shows that requests are dropped while no offset exists. A request issued during a SET pulse shows that the request is held and served in order.

// File: rtl/bridge_cal_pkg.sv
`timescale 1ns/1ps
package bridge_cal_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_WAIT_A, S_SET, S_GAP_B, S_READ_S,
    S_WAIT_C, S_RST, S_WAIT_D, S_READ_R, S_MEAS
  } cal_state_t;
endpackage

// File: rtl/recal_timer.sv
`timescale 1ns/1ps
module recal_timer #(
  parameter longint unsigned PERIOD = 600
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic due
);
  localparam int CW = $clog2(PERIOD + 1);
  logic [CW-1:0] cnt;

  // due is raised out of reset so the first calibration runs at once
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      due <= 1'b1;
    end else if (restart) begin
      cnt <= '0;
      due <= 1'b0;
    end else if (!due) begin
      if (cnt == CW'(PERIOD - 1)) due <= 1'b1;
      else cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_reader.sv
`timescale 1ns/1ps
module adc_reader #(
  parameter int unsigned DW = 12,
  parameter int unsigned TO = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          adc_done,
  input  logic [DW-1:0] adc_data,
  output logic          adc_start,
  output logic          ok,
  output logic          tout,
  output logic [DW-1:0] data
);
  localparam int TW = $clog2(TO + 1);
  logic          busy;
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      tcnt      <= '0;
      adc_start <= 1'b0;
      ok        <= 1'b0;
      tout      <= 1'b0;
      data      <= '0;
    end else begin
      adc_start <= 1'b0;
      ok        <= 1'b0;
      tout      <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy      <= 1'b1;
          adc_start <= 1'b1;
          tcnt      <= '0;
        end
      end else if (adc_done) begin
        busy <= 1'b0;
        ok   <= 1'b1;
        data <= adc_data;
      end else if (tcnt == TW'(TO - 1)) begin
        busy <= 1'b0;
        tout <= 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/offset_calc.sv
`timescale 1ns/1ps
module offset_calc #(
  parameter int unsigned DW = 12
) (
  input  logic [DW-1:0] vs,
  input  logic [DW-1:0] vr,
  input  logic [DW:0]   os_old,
  input  logic          use_new,
  input  logic [DW-1:0] samp,
  output logic [DW:0]   os_new,
  output logic [DW:0]   corr
);
  logic signed [DW:0] sum;
  logic signed [DW:0] base;

  always_comb begin
    // widened sum, then halve with floor rounding
    sum    = $signed({vs[DW-1], vs}) + $signed({vr[DW-1], vr});
    os_new = sum >>> 1;
    base   = use_new ? $signed(os_new) : $signed(os_old);
    corr   = $signed({samp[DW-1], samp}) - base;
  end
endmodule

// File: rtl/bridge_cal_seq.sv
`timescale 1ns/1ps
module bridge_cal_seq
  import bridge_cal_pkg::*;
#(
  parameter int unsigned     DATA_W       = 16,
  parameter int unsigned     PULSE_CYC    = 400,
  parameter int unsigned     WAIT_A_CYC   = 1100,
  parameter int unsigned     GAP_B_CYC    = 220,
  parameter int unsigned     SEP_C_CYC    = 4100,
  parameter int unsigned     SETTLE_D_CYC = 4100,
  parameter int unsigned     ADC_TO_CYC   = 2000,
  parameter longint unsigned RECAL_CYC    = 64'd120_000_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_req,
  output logic              set_pulse,
  output logic              rst_pulse,
  output logic              adc_start,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic [DATA_W:0]   corr_data,
  output logic              corr_valid,
  output logic              cal_err
);
  localparam int unsigned M1   = (WAIT_A_CYC > PULSE_CYC) ? WAIT_A_CYC : PULSE_CYC;
  localparam int unsigned M2   = (GAP_B_CYC > SETTLE_D_CYC) ? GAP_B_CYC : SETTLE_D_CYC;
  localparam int unsigned TMAX = (M1 > M2) ? M1 : M2;
  localparam int          CW   = $clog2(TMAX + 1);
  localparam int          SW   = $clog2(SEP_C_CYC + 1);

  cal_state_t st, st_n;
  logic [CW-1:0]     cnt;
  logic [SW-1:0]     since_set;
  logic              pend, cal_ok, due;
  logic [DATA_W-1:0] vs_q;
  logic [DATA_W:0]   os_q, os_new, corr_w;
  logic              go, rd_ok, rd_to;
  logic [DATA_W-1:0] rd_data;
  logic              load_vs, fin_cal, fin_meas, abandon, take_req;
  logic              hit_a, hit_pw, hit_b, hit_d, hit_c;

  assign hit_a  = (cnt == CW'(WAIT_A_CYC - 1));
  assign hit_pw = (cnt == CW'(PULSE_CYC - 1));
  assign hit_b  = (cnt == CW'(GAP_B_CYC - 1));
  assign hit_d  = (cnt == CW'(SETTLE_D_CYC - 1));
  assign hit_c  = (since_set == SW'(SEP_C_CYC - 1));

  recal_timer #(.PERIOD(RECAL_CYC)) timer_i (
    .clk(clk), .rst(rst), .restart(fin_cal | abandon), .due(due)
  );

  adc_reader #(.DW(DATA_W), .TO(ADC_TO_CYC)) reader_i (
    .clk(clk), .rst(rst), .go(go), .adc_done(adc_done), .adc_data(adc_data),
    .adc_start(adc_start), .ok(rd_ok), .tout(rd_to), .data(rd_data)
  );

  offset_calc #(.DW(DATA_W)) calc_i (
    .vs(vs_q), .vr(rd_data), .os_old(os_q), .use_new(st == S_READ_R),
    .samp(rd_data), .os_new(os_new), .corr(corr_w)
  );

  always_comb begin
    st_n     = st;
    go       = 1'b0;
    load_vs  = 1'b0;
    fin_cal  = 1'b0;
    fin_meas = 1'b0;
    abandon  = 1'b0;
    take_req = 1'b0;
    case (st)
      S_IDLE: begin
        if (due) st_n = S_WAIT_A;
        else if (pend) begin
          take_req = 1'b1;
          if (cal_ok) begin
            st_n = S_MEAS;
            go   = 1'b1;
          end
        end
      end
      S_WAIT_A: if (hit_a) st_n = S_SET;
      S_SET:    if (hit_pw) st_n = S_GAP_B;
      S_GAP_B: if (hit_b) begin
        st_n = S_READ_S;
        go   = 1'b1;
      end
      S_READ_S: begin
        if (rd_ok) begin
          load_vs = 1'b1;
          st_n    = S_WAIT_C;
        end else if (rd_to) begin
          abandon = 1'b1;
          st_n    = S_IDLE;
        end
      end
      S_WAIT_C: if (hit_c) st_n = S_RST;
      S_RST:    if (hit_pw) st_n = S_WAIT_D;
      S_WAIT_D: if (hit_d) begin
        st_n = S_READ_R;
        go   = 1'b1;
      end
      S_READ_R: begin
        if (rd_ok) begin
          fin_cal = 1'b1;
          st_n    = S_IDLE;
        end else if (rd_to) begin
          abandon = 1'b1;
          st_n    = S_IDLE;
        end
      end
      S_MEAS: begin
        if (rd_ok) begin
          fin_meas = 1'b1;
          st_n     = S_IDLE;
        end else if (rd_to) st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      since_set  <= '0;
      pend       <= 1'b0;
      cal_ok     <= 1'b0;
      vs_q       <= '0;
      os_q       <= '0;
      corr_data  <= '0;
      corr_valid <= 1'b0;
      cal_err    <= 1'b0;
      set_pulse  <= 1'b0;
      rst_pulse  <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= (st_n != st) ? '0 : cnt + 1'b1;
      set_pulse <= (st_n == S_SET);
      rst_pulse <= (st_n == S_RST);
      if (st_n == S_SET && st != S_SET) since_set <= '0;
      else if (!hit_c) since_set <= since_set + 1'b1;
      if (take_req) pend <= 1'b0;
      if (meas_req) pend <= 1'b1;
      if (load_vs) vs_q <= rd_data;
      if (rd_to) cal_err <= 1'b1;
      corr_valid <= fin_cal | fin_meas;
      if (fin_cal | fin_meas) corr_data <= corr_w;
      if (fin_cal) begin
        os_q   <= os_new;
        cal_ok <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bridge_cal_chk.sv
`timescale 1ns/1ps
module bridge_cal_chk #(
  parameter int unsigned PULSE_CYC = 4
) (
  input logic clk,
  input logic rst,
  input logic set_pulse,
  input logic rst_pulse,
  input logic adc_start,
  input logic corr_valid,
  input logic cal_err
);
  int unsigned set_len, rst_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      set_len <= 0;
      rst_len <= 0;
    end else begin
      set_len <= set_pulse ? set_len + 1 : 0;
      rst_len <= rst_pulse ? rst_len + 1 : 0;
    end
  end

  // R1
  strap_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(set_pulse && rst_pulse));
  // R1
  set_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(set_pulse) |-> set_len == PULSE_CYC);
  // R1
  rst_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_pulse) |-> rst_len == PULSE_CYC);
  // R2
  quiet_strap_chk: assert property (@(posedge clk) disable iff (rst)
    (set_pulse || rst_pulse) |-> !adc_start);
  // R8
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cal_err |=> cal_err);
  // R4
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    corr_valid |=> !corr_valid);
endmodule

bind bridge_cal_seq bridge_cal_chk #(.PULSE_CYC(PULSE_CYC)) chk_i (
  .clk(clk), .rst(rst), .set_pulse(set_pulse), .rst_pulse(rst_pulse),
  .adc_start(adc_start), .corr_valid(corr_valid), .cal_err(cal_err)
);

// File: tb/bridge_cal_seq_tb_top.sv
`timescale 1ns/1ps
module bridge_cal_seq_tb_top;
  localparam int W  = 12;
  localparam int PW = 4;
  localparam int A  = 6;
  localparam int B  = 3;
  localparam int C  = 40;
  localparam int D  = 8;
  localparam int TO = 20;
  localparam int RC = 600;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, meas_req, set_pulse, rst_pulse, adc_start, adc_done;
  logic corr_valid, cal_err;
  logic [W-1:0] adc_data;
  logic [W:0]   corr_data;

  bridge_cal_seq #(
    .DATA_W(W), .PULSE_CYC(PW), .WAIT_A_CYC(A), .GAP_B_CYC(B),
    .SEP_C_CYC(C), .SETTLE_D_CYC(D), .ADC_TO_CYC(TO), .RECAL_CYC(RC)
  ) dut_i (
    .clk(clk), .rst(rst), .meas_req(meas_req), .set_pulse(set_pulse),
    .rst_pulse(rst_pulse), .adc_start(adc_start), .adc_done(adc_done),
    .adc_data(adc_data), .corr_data(corr_data), .corr_valid(corr_valid),
    .cal_err(cal_err)
  );

  int total = 0, bad = 0;
  bit silent = 1'b1;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd_val();
    return int'($urandom_range(0, (1 << W) - 1)) - (1 << (W - 1));
  endfunction

  function automatic int floor_half(input int s);
    if (s < 0 && (s % 2) != 0) return s / 2 - 1;
    return s / 2;
  endfunction

  function automatic int vs_of(input int k);
    case (k)
      0: return 2047;
      1: return -2048;
      2: return -1;
      3: return 2047;
      default: return rnd_val();
    endcase
  endfunction

  function automatic int vr_of(input int k);
    case (k)
      0: return 2047;
      1: return -2048;
      2: return 0;
      3: return -2048;
      default: return rnd_val();
    endcase
  endfunction

  function automatic int meas_of(input int k);
    case (k)
      0: return -2048;
      1: return 2047;
      default: return rnd_val();
    endcase
  endfunction

  // monitor and ADC model, all at the falling edge
  int cyc, set_rise, set_fall, rst_fall, set_cnt, rst_cnt, last_fin;
  int nset, nrst, cal_outs, meas_outs, phase, kind, pend_kind, lat;
  int pair_k, meas_k, cur_vs, cur_os, exp_out;
  bit set_q, rst_q, err_q, busy;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; nset = 0; nrst = 0; cal_outs = 0; meas_outs = 0;
      phase = 0; kind = 0; pend_kind = 0; busy = 0; lat = 0;
      pair_k = 0; meas_k = 0; cur_vs = 0; cur_os = 0; exp_out = 0;
      set_q = 0; rst_q = 0; err_q = 0; last_fin = -1;
      set_cnt = 0; rst_cnt = 0; set_rise = 0; set_fall = 0; rst_fall = 0;
      adc_done = 0; adc_data = '0;
    end else begin
      cyc++;
      adc_done = 0;
      if (set_pulse && !set_q) begin
        nset++; set_rise = cyc; set_cnt = 1; phase = 1;
        if (nset == 1) chk(cyc >= A, "R2 lead-in before first SET", cyc, A);
        else chk(cyc - last_fin >= RC + A - 2 && cyc - last_fin <= RC + A + 40,
                 "R9 recalibration interval", cyc - last_fin, RC + A + 1);
      end else if (set_pulse) set_cnt++;
      if (!set_pulse && set_q) begin
        chk(set_cnt == PW, "R1 SET width", set_cnt, PW);
        set_fall = cyc;
      end
      if (rst_pulse && !rst_q) begin
        nrst++; rst_cnt = 1;
        chk(cyc - set_rise >= C, "R3 SET-to-RESET spacing", cyc - set_rise, C);
        chk(phase == 3, "R1 RESET after Vset read", phase, 3);
        phase = 4;
      end else if (rst_pulse) rst_cnt++;
      if (!rst_pulse && rst_q) begin
        chk(rst_cnt == PW, "R1 RESET width", rst_cnt, PW);
        rst_fall = cyc;
      end
      if (cal_err && !err_q) last_fin = cyc;
      if (adc_start) begin
        if (phase == 1) begin
          kind = 1; phase = 2;
          chk(cyc - set_fall >= B, "R2 gap before Vset read", cyc - set_fall, B);
        end else if (phase == 4) begin
          kind = 2; phase = 5;
          chk(cyc - rst_fall >= D, "R3 settle before Vrst read", cyc - rst_fall, D);
        end else kind = 3;
        if (!silent) begin
          busy = 1; lat = 1 + int'($urandom_range(0, 5));
        end
      end else if (busy) begin
        lat--;
        if (lat == 0) begin
          int v;
          busy = 0;
          pend_kind = kind;
          if (kind == 1) begin
            v = vs_of(pair_k); cur_vs = v; phase = 3;
          end else if (kind == 2) begin
            v = vr_of(pair_k); pair_k++;
            cur_os = floor_half(cur_vs + v);
            exp_out = v - cur_os; phase = 0;
          end else begin
            v = meas_of(meas_k); meas_k++;
            exp_out = v - cur_os;
          end
          adc_done = 1; adc_data = W'(v);
        end
      end
      if (corr_valid) begin
        if (pend_kind == 2) begin
          cal_outs++; last_fin = cyc;
          chk(int'($signed(corr_data)) == exp_out, "R4 calibration output",
              int'($signed(corr_data)), exp_out);
        end else if (pend_kind == 3) begin
          meas_outs++;
          chk(int'($signed(corr_data)) == exp_out, "R5 corrected reading",
              int'($signed(corr_data)), exp_out);
        end else chk(0, "R7 unexpected output", 1, 0);
        pend_kind = 0;
      end
      set_q = set_pulse; rst_q = rst_pulse; err_q = cal_err;
    end
  end

  task automatic do_meas();
    int m0, s0, n;
    m0 = meas_outs; s0 = nset;
    meas_req = 1; @(negedge clk); meas_req = 0;
    n = 0;
    while (meas_outs == m0 && n < 200) begin @(negedge clk); n++; end
    chk(meas_outs == m0 + 1, "R5 request served", meas_outs - m0, 1);
    chk(nset == s0, "R5 no strap pulse on read", nset - s0, 0);
  endtask

  initial begin
    int n;
    void'($urandom(32'h1F2E));
    rst = 1; meas_req = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({set_pulse, rst_pulse, adc_start, corr_valid, cal_err} == 5'b0,
        "R10 outputs low in reset",
        int'({set_pulse, rst_pulse, adc_start, corr_valid, cal_err}), 0);
    rst = 0;
    n = 0;
    while (!cal_err && n < 600) begin @(negedge clk); n++; end
    chk(cal_err == 1'b1, "R8 timeout raises error", int'(cal_err), 1);
    chk(nrst == 0, "R8 abandoned without RESET", nrst, 0);
    chk(nset == 1, "R9 calibration right after reset", nset, 1);
    meas_req = 1; @(negedge clk); meas_req = 0;
    repeat (100) @(negedge clk);
    chk(meas_outs == 0 && cal_outs == 0, "R7 no output before calibration",
        meas_outs + cal_outs, 0);
    silent = 0;
    for (int k = 0; k < 7; k++) begin
      if (k == 3) begin
        int c0, m0;
        n = 0;
        while (!set_pulse && n < 1500) begin @(negedge clk); n++; end
        c0 = cal_outs; m0 = meas_outs;
        meas_req = 1; @(negedge clk); meas_req = 0;
        n = 0;
        while (meas_outs == m0 && n < 1500) begin @(negedge clk); n++; end
        chk(meas_outs == m0 + 1, "R6 held request served", meas_outs - m0, 1);
        chk(cal_outs == c0 + 1, "R6 served after calibration", cal_outs - c0, 1);
      end
      n = 0;
      while (cal_outs <= k && n < 1500) begin @(negedge clk); n++; end
      chk(cal_outs == k + 1, "R9 calibration completed", cal_outs, k + 1);
      do_meas();
      do_meas();
    end
    chk(cal_err == 1'b1, "R8 error stays set", int'(cal_err), 1);
    chk(nrst == 7, "R1 one RESET per completed calibration", nrst, 7);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule